// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Writer

This block stores received frames into memory buffers. Software lays out a ring of three-word descriptors in memory, gives the block the word address of the ring's first descriptor, and arms it with a one-cycle pulse. While armed, the block reads the current descriptor through a single word-addressed memory port and checks that hardware owns it. It then takes frame bytes from an incoming byte stream and packs them into buffer words, writing each word with byte enables. When the frame ends, it writes the length and status back into the descriptor, hands ownership back to software, and moves on to the next descriptor.

If a descriptor is not owned by hardware, the block consumes and discards the next frame. It then stops by clearing its run flag, and does not move the ring pointer. A later arm pulse makes it fetch the same descriptor again. The ring pointer is kept as an offset from the base input. It starts at zero after reset and returns to zero after a descriptor flagged as ring-end.

The byte input is a valid/ready stream. A byte is transferred on a rising edge where `in_valid` and `in_ready` are both high. The sender holds the byte and its markers stable until that edge. `in_ready` is low while the block is stopped, while it fetches a descriptor, while a packed buffer word waits for the memory port, and during write-back. The memory port is a request/grant interface. A request and its address, data and enables are held until the cycle in which `mem_gnt` is high. Read data returns with `mem_rvalid` on a later cycle, and only one read is outstanding at a time.

Top module: `rx_ring_writer`

## Requirements
- R1: A descriptor occupies three consecutive memory words at `ring_base_i` plus the ring offset. Word 0 holds the flags: bit 31 hardware-owned, bit 30 ring-end, bit 29 frame-error. Word 1 holds the buffer size in bytes in bits 31:16 and the stored length in bits 15:0. Word 2 holds the buffer byte address. Word 2 is never written by the block.
- R2: Frame byte k goes to word (buffer address >> 2) + k/4, in byte lane k mod 4 (lane 0 = bits 7:0). The low 5 bits of the buffer address are ignored, because buffers are 32-byte aligned. Bytes of the buffer past the stored length are left unchanged, because only the lanes that hold frame bytes are enabled.
- R3: At frame end the block writes word 1 as {buffer size, stored length}, then writes word 0 with bit 31 cleared, bit 30 copied from the fetched word 0, bit 29 set to the frame status, and all other bits zero.
- R4: A frame whose last byte carries `in_err` gets bit 29 set in word 0. A clean frame that fits its buffer gets bit 29 cleared.
- R5: A frame longer than the buffer size is cut at the buffer size: the stored length equals the size, the extra bytes are discarded, and bit 29 is set. A frame exactly as long as the buffer is not treated as truncated.
- R6: After write-back the offset returns to zero if the descriptor had bit 30 set. Otherwise it grows by three words.
- R7: If a fetched word 0 has bit 31 clear, the block accepts and discards bytes up to and including the next byte marked `in_last`. It writes nothing to memory, clears `rx_run_o`, and keeps the ring offset, so that the next arm fetches the same descriptor.
- R8: After reset `rx_run_o` is 0, and `in_ready` is 0 whenever `rx_run_o` is 0. A pulse on `rx_arm_i` sets `rx_run_o` on the next edge.
- R9: `in_ready` is 0 while a descriptor is being fetched. In particular it is 0 in the cycle right after an arm pulse.
- R10: While waiting for a frame in a fetched descriptor, bytes without `in_first` are accepted and discarded, and they do not count toward the length.
- R11: A memory request that is not granted is repeated in the next cycle with the same address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ring_base_i | input | AW | Word address of the first descriptor |
| rx_arm_i | input | 1 | One-cycle pulse that sets the run flag |
| rx_run_o | output | 1 | Run flag; cleared by the block on a non-owned descriptor |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte ready |
| in_data | input | 8 | Stream byte |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| in_err | input | 1 | Frame error, qualified by `in_last` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench builds the block with AW = 10, a 1024-word memory model, a four-descriptor ring at word 64, and buffers 256 bytes apart. Two descriptors get small buffer sizes (7 and 10 bytes), so exact-fit and truncated frames occur often under random frame lengths up to 80 bytes. The same test also covers whole-buffer frames and ring wrap-around. A random grant pattern keeps memory requests waiting, and random gaps on the byte stream vary the packing timing. Directed steps cover a descriptor that is not owned, re-arming the block, and stray bytes before a frame start.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int FLAG_OWNED   = 31;
  localparam int FLAG_RINGEND = 30;
  localparam int FLAG_FRMERR  = 29;
  localparam int DESC_WORDS   = 3;
  localparam int LEN_W        = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_FWAIT,
    ST_RECV,
    ST_DROP,
    ST_WB_LEN,
    ST_WB_FLAGS
  } rx_state_e;
endpackage

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  input  logic          wrap_i,
  output logic [AW-1:0] desc_addr_o
);
  import rx_ring_pkg::*;

  logic [AW-1:0] offset_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) offset_q <= '0;
    else if (step_i) offset_q <= wrap_i ? '0 : offset_q + AW'(DESC_WORDS);
  end

  assign desc_addr_o = base_i + offset_q;
endmodule

// File: rtl/rx_byte_packer.sv
module rx_byte_packer #(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 put_i,
  input  logic [$clog2(LANES)-1:0] lane_i,
  input  logic [7:0]           byte_i,
  input  logic                 drain_i,
  output logic [8*LANES-1:0]   word_o,
  output logic [LANES-1:0]     be_o
);
  localparam int LW = $clog2(LANES);

  logic [LANES-1:0][7:0] data_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[g] <= '0;
        be_o[g]   <= 1'b0;
      end else if (put_i && lane_i == LW'(g)) begin
        data_q[g] <= byte_i;
        be_o[g]   <= 1'b1;
      end else if (drain_i) begin
        be_o[g]   <= 1'b0;
      end
    end
    assign word_o[8*g +: 8] = data_q[g];
  end

  // R2: a drained word always carries at least one enabled lane
  assert_drain_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drain_i |-> be_o != '0);
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base_i,
  input  logic          rx_arm_i,
  output logic          rx_run_o,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_first,
  input  logic          in_last,
  input  logic          in_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata
);
  import rx_ring_pkg::*;

  localparam int BUF_HI = AW + 1;

  rx_state_e        state;
  logic [1:0]       fidx;
  logic             ring_end;
  logic [LEN_W-1:0] buf_size;
  logic [AW-1:0]    buf_wbase;
  logic [LEN_W-1:0] len;
  logic             started, done_rx, trunc, frm_err, pend;
  logic [AW-1:0]    wr_addr;
  logic [AW-1:0]    desc_addr;
  logic [31:0]      pk_word;
  logic [3:0]       pk_be;
  logic             accept, take, fits, step;
  logic             unused_rdata;

  assign unused_rdata = ^mem_rdata;

  assign accept = in_valid && in_ready;
  assign take   = (state == ST_RECV) && accept && (started || in_first);
  assign fits   = len < buf_size;
  assign step   = (state == ST_WB_FLAGS) && mem_gnt;

  rx_ring_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .base_i(ring_base_i),
    .step_i(step), .wrap_i(ring_end), .desc_addr_o(desc_addr)
  );

  rx_byte_packer #(.LANES(4)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .put_i(take && fits), .lane_i(len[1:0]), .byte_i(in_data),
    .drain_i((state == ST_RECV) && pend && mem_gnt),
    .word_o(pk_word), .be_o(pk_be)
  );

  always_comb begin
    in_ready = 1'b0;
    if (state == ST_RECV) in_ready = !pend && !done_rx;
    else if (state == ST_DROP) in_ready = 1'b1;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    mem_be    = 4'hF;
    case (state)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(fidx);
      end
      ST_RECV: if (pend) begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = wr_addr;
        mem_wdata = pk_word;
        mem_be    = pk_be;
      end
      ST_WB_LEN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + AW'(1);
        mem_wdata = {buf_size, len};
      end
      ST_WB_FLAGS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata[FLAG_RINGEND] = ring_end;
        mem_wdata[FLAG_FRMERR]  = frm_err || trunc;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_run_o <= 1'b0;
    end else if (rx_arm_i) begin
      rx_run_o <= 1'b1;
    end else if (state == ST_DROP && accept && in_last) begin
      rx_run_o <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      fidx      <= '0;
      ring_end  <= 1'b0;
      buf_size  <= '0;
      buf_wbase <= '0;
      len       <= '0;
      started   <= 1'b0;
      done_rx   <= 1'b0;
      trunc     <= 1'b0;
      frm_err   <= 1'b0;
      pend      <= 1'b0;
      wr_addr   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (rx_run_o) begin
          state <= ST_FETCH;
          fidx  <= 2'd0;
        end
        ST_FETCH: if (mem_gnt) state <= ST_FWAIT;
        ST_FWAIT: if (mem_rvalid) begin
          case (fidx)
            2'd0: begin
              ring_end <= mem_rdata[FLAG_RINGEND];
              if (!mem_rdata[FLAG_OWNED]) begin
                state <= ST_DROP;
              end else begin
                fidx  <= 2'd1;
                state <= ST_FETCH;
              end
            end
            2'd1: begin
              buf_size <= mem_rdata[31:16];
              fidx     <= 2'd2;
              state    <= ST_FETCH;
            end
            default: begin
              buf_wbase <= {mem_rdata[BUF_HI:5], 3'b000};
              len       <= '0;
              started   <= 1'b0;
              done_rx   <= 1'b0;
              trunc     <= 1'b0;
              frm_err   <= 1'b0;
              pend      <= 1'b0;
              state     <= ST_RECV;
            end
          endcase
        end
        ST_RECV: begin
          if (pend && mem_gnt) pend <= 1'b0;
          if (take) begin
            started <= 1'b1;
            if (fits) begin
              len     <= len + 1'b1;
              wr_addr <= buf_wbase + AW'(len[LEN_W-1:2]);
              pend    <= (len[1:0] == 2'd3) || in_last || (len + 1'b1 == buf_size);
            end
            if (in_last) begin
              done_rx <= 1'b1;
              frm_err <= in_err;
            end
            if (!fits) trunc <= 1'b1;
          end
          if (done_rx && !pend) state <= ST_WB_LEN;
        end
        ST_DROP: if (accept && in_last) state <= ST_IDLE;
        ST_WB_LEN: if (mem_gnt) state <= ST_WB_FLAGS;
        ST_WB_FLAGS: if (mem_gnt) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: no byte is taken while the block is stopped
  assert_stopped_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_run_o |-> !in_ready);

  // R11: a waiting request keeps its address and direction
  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R5: the stored length never passes the buffer size
  assert_len_within_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RECV |-> len <= buf_size);

  // R3: the flags word is written only right after the length word
  assert_wb_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WB_FLAGS |-> $past(state) == ST_WB_LEN || $past(state) == ST_WB_FLAGS);

  // R7: the block only stops itself at the end of a dropped frame
  assert_stop_after_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_run_o) |-> $past(state) == ST_DROP);
endmodule

// File: tb/rx_ring_writer_test.sv
module rx_ring_writer_test;
  localparam int AW = 10;
  localparam int BASE = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_arm = 1'b0;
  logic rx_run;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_err = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0] mem_be;
  logic mem_gnt = 1'b0;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  rx_ring_writer #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ring_base_i(AW'(BASE)), .rx_arm_i(rx_arm), .rx_run_o(rx_run),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_first(in_first),
    .in_last(in_last), .in_err(in_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem [0:1023];
  logic tb_wr = 1'b0;
  logic [AW-1:0] tb_a = '0;
  logic [31:0] tb_d = '0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (tb_wr) mem[tb_a] <= tb_d;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) mem[mem_addr][8*l +: 8] <= mem_wdata[8*l +: 8];
      end else begin
        mem_rdata  <= mem[mem_addr];
        mem_rvalid <= 1'b1;
      end
    end
  end

  int r11_bad = 0;
  logic prev_wait = 1'b0, prev_we = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  always @(negedge clk) begin
    if (prev_wait && !(mem_req && mem_addr == prev_addr && mem_we == prev_we)) r11_bad++;
    mem_gnt = ($urandom_range(0, 3) != 0);
    prev_wait = rst_n && mem_req && !mem_gnt;
    prev_addr = mem_addr;
    prev_we = mem_we;
  end

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] frm [0:255];
  int dsz [0:3];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input int a, input logic [31:0] d);
    @(negedge clk);
    tb_wr = 1'b1; tb_a = AW'(a); tb_d = d;
    @(negedge clk);
    tb_wr = 1'b0;
  endtask

  function automatic int bufbyte(input int di);
    return 32'h400 + di * 32'h100;
  endfunction

  task automatic rearm(input int di);
    logic [31:0] w0;
    w0 = 32'h8000_1234 | ((di == 3) ? 32'h4000_0000 : 32'h0);
    for (int k = 0; k < 64; k++) bwrite(bufbyte(di) / 4 + k, 32'hA5A5_A5A5);
    bwrite(BASE + 3 * di + 2, bufbyte(di) + 32'h13);
    bwrite(BASE + 3 * di + 1, {dsz[di][15:0], 16'hBEEF});
    bwrite(BASE + 3 * di, w0);
  endtask

  task automatic fill_frame(input int n);
    for (int k = 0; k < n; k++) frm[k] = 8'($urandom);
  endtask

  task automatic send_frame(input int n, input bit er, input int nstray);
    bit ok;
    for (int k = 0; k < nstray + n; k++) begin
      int gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) @(negedge clk);
      in_valid = 1'b1;
      in_data  = (k < nstray) ? 8'h3C : frm[k - nstray];
      in_first = (k == nstray);
      in_last  = (k == nstray + n - 1);
      in_err   = er && (k == nstray + n - 1);
      ok = 1'b0;
      while (!ok) begin
        ok = in_ready;
        @(negedge clk);
      end
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_err = 1'b0;
    end
  endtask

  task automatic wait_done(input int di);
    int t = 0;
    while (mem[BASE + 3 * di][31] !== 1'b0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
  endtask

  task automatic check_desc(input int di, input int flen, input bit er, input string tag);
    int dw = BASE + 3 * di;
    int sz = dsz[di];
    int st = (flen < sz) ? flen : sz;
    bit e = er || (flen > sz);
    int bw = bufbyte(di) / 4;
    int lim = (sz + 4 < 256) ? sz + 4 : 256;
    int bad = 0;
    logic [31:0] exp0;
    exp0 = {1'b0, (di == 3), e, 29'b0};
    chk(mem[dw] === exp0, {tag, " R3 R4 flags word"}, mem[dw], exp0);
    chk(mem[dw + 1] === {sz[15:0], st[15:0]}, {tag, " R5 R3 length word"}, mem[dw + 1], {sz[15:0], st[15:0]});
    chk(mem[dw + 2] === bufbyte(di) + 32'h13, {tag, " R1 address word untouched"}, mem[dw + 2], bufbyte(di) + 32'h13);
    for (int k = 0; k < lim; k++) begin
      logic [7:0] ex = (k < st) ? frm[k] : 8'hA5;
      if (mem[bw + k / 4][8 * (k % 4) +: 8] !== ex) bad++;
    end
    chk(bad == 0, {tag, " R2 buffer bytes"}, bad, 0);
  endtask

  initial begin
    int cur;
    logic [31:0] d1_w0, d1_w1, d1_b0;
    void'($urandom(32'd20240611));
    dsz[0] = 200; dsz[1] = 7; dsz[2] = 10; dsz[3] = 200;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_run == 1'b0, "R8 run after reset", rx_run, 0);
    in_valid = 1'b1; in_first = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b0 && mem_req == 1'b0, "R8 stopped: no ready, no request", {in_ready, mem_req}, 0);
    end
    in_valid = 1'b0; in_first = 1'b0;
    for (int di = 0; di < 4; di++) rearm(di);

    @(negedge clk); rx_arm = 1'b1;
    @(negedge clk); rx_arm = 1'b0;
    chk(rx_run == 1'b1, "R8 arm sets run", rx_run, 1);
    chk(in_ready == 1'b0, "R9 not ready while fetching", in_ready, 0);

    fill_frame(13); send_frame(13, 0, 0); wait_done(0);
    check_desc(0, 13, 0, "R1 frame A"); rearm(0);

    fill_frame(7); send_frame(7, 1, 0); wait_done(1);
    check_desc(1, 7, 1, "R4 frame B exact fit with error");
    d1_w0 = mem[BASE + 3]; d1_w1 = mem[BASE + 4]; d1_b0 = mem[bufbyte(1) / 4];

    fill_frame(25); send_frame(25, 0, 0); wait_done(2);
    check_desc(2, 25, 0, "R5 frame C truncated"); rearm(2);

    fill_frame(64); send_frame(64, 0, 0); wait_done(3);
    check_desc(3, 64, 0, "R6 frame D ring end"); rearm(3);

    fill_frame(31); send_frame(31, 0, 0); wait_done(0);
    check_desc(0, 31, 0, "R6 frame E wraps to first"); rearm(0);

    fill_frame(9); send_frame(9, 0, 0);
    repeat (4) @(negedge clk);
    chk(rx_run == 1'b0, "R7 run cleared on non-owned", rx_run, 0);
    chk(mem[BASE + 3] === d1_w0, "R7 flags untouched", mem[BASE + 3], d1_w0);
    chk(mem[BASE + 4] === d1_w1, "R7 length untouched", mem[BASE + 4], d1_w1);
    chk(mem[bufbyte(1) / 4] === d1_b0, "R7 buffer untouched", mem[bufbyte(1) / 4], d1_b0);
    chk(in_ready == 1'b0, "R8 not ready after stop", in_ready, 0);

    rearm(1);
    @(negedge clk); rx_arm = 1'b1;
    @(negedge clk); rx_arm = 1'b0;
    fill_frame(5); send_frame(5, 0, 3); wait_done(1);
    check_desc(1, 5, 0, "R10 R7 refetch with stray bytes"); rearm(1);

    cur = 2;
    for (int f = 0; f < 24; f++) begin
      int n = $urandom_range(1, 80);
      bit er = ($urandom_range(0, 3) == 0);
      fill_frame(n); send_frame(n, er, 0); wait_done(cur);
      check_desc(cur, n, er, "R2 R5 random frame");
      rearm(cur);
      cur = (cur == 3) ? 0 : cur + 1;
    end
    chk(r11_bad == 0, "R11 waiting requests held", r11_bad, 0);
    chk(rx_run == 1'b1, "R8 still running", rx_run, 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule